// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped First-Level Cache

This block is a small fully associative store that sits on the miss path of a direct-mapped first-level cache. Whenever the first-level array throws a line out to make room, it hands that line over: block number, line data and its modified flag. When the first-level cache later misses, it asks this buffer before it goes to the next memory level. On a match the line comes back in the same cycle with its modified flag, and the buffer entry is released, because the line now lives in the first-level array again.

The buffer never loads lines from the next level. It only takes lines that the first-level cache has discarded. When every entry is occupied, a new line displaces the entries in arrival order. If a displaced entry is modified, it leaves through a valid/ready write-back port. While that write-back has not been accepted, the buffer refuses new lines but keeps answering lookups. If a line arrives in the same cycle that a lookup hits, the two lines swap places and nothing is written back.

The default geometry is a 24-bit byte address with 4-byte lines. Entries are therefore tagged with the 22-bit block number, which is address bits 23:2.

Top module: `victim_buffer`

## Requirements
- R1: A lookup (`lk_valid` high) compares `lk_blk` against every valid entry at once. On a match, `lk_hit`, `lk_line` and `lk_dirty` show that entry's line and modified flag in the same cycle. Otherwise `lk_hit` is low.
- R2: After a lookup hit, the matching entry is invalid from the next cycle on, so a repeated lookup of the same block misses.
- R3: An accepted insert (`ins_valid` and `ins_ready`) goes into the lowest-numbered free entry while any entry is free. In that case no write-back is raised.
- R4: With every entry valid, an insert replaces entries in first-in first-out order. A rotating pointer starts at entry 0 after reset and advances by one, wrapping at the entry count, on each insert into a full buffer.
- R5: When the replaced entry is modified, `wb_valid` rises on the next cycle with that entry's block number and line. These stay unchanged until `wb_ready` is sampled high. A clean replaced entry raises no write-back.
- R6: While `wb_valid` is high, `ins_ready` is low and an offered insert changes no entry.
- R7: An insert accepted in the same cycle as a lookup hit takes the entry the hit frees. No write-back is raised and no other entry is lost.
- R8: Reset invalidates every entry and clears every modified flag, lowers `wb_valid` and raises `ins_ready`.
- R9: Lookups are answered normally while a write-back is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Line offered by the first-level eviction path |
| ins_ready | output | 1 | Buffer can take an offered line |
| ins_blk | input | 22 | Block number of the offered line |
| ins_line | input | 32 | Data of the offered line |
| ins_dirty | input | 1 | Offered line is modified |
| lk_valid | input | 1 | Lookup request from the first-level miss path |
| lk_blk | input | 22 | Block number looked up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_line | output | 32 | Data of the matching entry |
| lk_dirty | output | 1 | Modified flag of the matching entry |
| wb_valid | output | 1 | Displaced modified line awaits the next level |
| wb_ready | input | 1 | Next level accepts the write-back |
| wb_blk | output | 22 | Block number of the written-back line |
| wb_line | output | 32 | Data of the written-back line |

## Verification
Directed traffic first fills the buffer through free entries and then punches a hole with a hit. This separates lowest-free placement from pointer-driven replacement. A clean displacement and a modified displacement in a row show that only modified lines leave through the write-back port. Holding `wb_ready` low exposes refused inserts while lookups still work. A combined insert and hit shows that a swap neither writes back nor disturbs the other entries. A long random phase then mixes inserts, hits, misses and back-pressure, and a behavioural model of slots and arrival order is compared against the ports on every cycle.

// File: rtl/vc_pkg.sv
package vc_pkg;

    // how an accepted insert finds its entry
    typedef enum logic [1:0] {
        PICK_FREE  = 2'd0,
        PICK_SWAP  = 2'd1,
        PICK_EVICT = 2'd2
    } pick_e;

    function automatic int wrap_next(int cur, int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 22
) (
    input  logic               req,
    input  logic [TAG_W-1:0]   req_blk,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [TAG_W-1:0]   blk_tab [ENTRIES],
    output logic [ENTRIES-1:0] hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = req && valid_vec[g] && (blk_tab[g] == req_blk);
    end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc
    import vc_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic               ins_fire,
    output pick_e              kind,
    output logic [ENTRIES-1:0] slot_oh
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [PTR_W-1:0]   fifo_ptr;
    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] free_low;

    assign free_vec = ~valid_vec;
    assign free_low = free_vec & (~free_vec + ENTRIES'(1));

    always_comb begin
        if (|hit_vec) begin
            kind    = PICK_SWAP;
            slot_oh = hit_vec;
        end else if (|free_vec) begin
            kind    = PICK_FREE;
            slot_oh = free_low;
        end else begin
            kind    = PICK_EVICT;
            slot_oh = ENTRIES'(1) << fifo_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_ptr <= '0;
        end else if (ins_fire && kind == PICK_EVICT) begin
            fifo_ptr <= PTR_W'(wrap_next(int'(fifo_ptr), ENTRIES));
        end
    end
endmodule

// File: rtl/vc_wb.sv
module vc_wb #(
    parameter int TAG_W  = 22,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TAG_W-1:0]  load_blk,
    input  logic [LINE_W-1:0] load_line,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [TAG_W-1:0]  wb_blk,
    output logic [LINE_W-1:0] wb_line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_blk   <= '0;
            wb_line  <= '0;
        end else if (load) begin
            wb_valid <= 1'b1;
            wb_blk   <= load_blk;
            wb_line  <= load_line;
        end else if (wb_valid && wb_ready) begin
            wb_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vc_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int ADDR_W   = 24,
    parameter int OFFSET_W = 2,
    localparam int TAG_W   = ADDR_W - OFFSET_W,
    localparam int LINE_W  = 8 << OFFSET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [TAG_W-1:0]  ins_blk,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              ins_dirty,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_blk,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_line,
    output logic              lk_dirty,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [TAG_W-1:0]  wb_blk,
    output logic [LINE_W-1:0] wb_line
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [TAG_W-1:0]   blk_q  [ENTRIES];
    logic [LINE_W-1:0]  line_q [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] slot_oh;
    pick_e              kind;
    logic               ins_fire;
    logic               vic_dirty;
    logic [TAG_W-1:0]   vic_blk;
    logic [LINE_W-1:0]  vic_line;
    logic               wb_load;

    vc_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .req       (lk_valid),
        .req_blk   (lk_blk),
        .valid_vec (valid_q),
        .blk_tab   (blk_q),
        .hit_vec   (hit_vec)
    );

    vc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_q),
        .hit_vec   (hit_vec),
        .ins_fire  (ins_fire),
        .kind      (kind),
        .slot_oh   (slot_oh)
    );

    vc_wb #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .load      (wb_load),
        .load_blk  (vic_blk),
        .load_line (vic_line),
        .wb_valid  (wb_valid),
        .wb_ready  (wb_ready),
        .wb_blk    (wb_blk),
        .wb_line   (wb_line)
    );

    assign ins_ready = !wb_valid;
    assign ins_fire  = ins_valid && ins_ready;
    assign lk_hit    = |hit_vec;

    // one-hot selects become OR trees
    always_comb begin
        lk_line   = '0;
        lk_dirty  = 1'b0;
        vic_dirty = 1'b0;
        vic_blk   = '0;
        vic_line  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_line  = lk_line | line_q[i];
                lk_dirty = lk_dirty | dirty_q[i];
            end
            if (slot_oh[i]) begin
                vic_dirty = vic_dirty | (valid_q[i] & dirty_q[i]);
                vic_blk   = vic_blk | blk_q[i];
                vic_line  = vic_line | line_q[i];
            end
        end
    end

    assign wb_load = ins_fire && (kind == PICK_EVICT) && vic_dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ins_fire && slot_oh[i]) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= ins_dirty;
                end else if (hit_vec[i]) begin
                    valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (ins_fire && slot_oh[i]) begin
                blk_q[i]  <= ins_blk;
                line_q[i] <= ins_line;
            end
        end
    end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
    parameter int TAG_W  = 22,
    parameter int LINE_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [TAG_W-1:0]  ins_blk,
    input logic [LINE_W-1:0] ins_line,
    input logic              lk_valid,
    input logic [TAG_W-1:0]  lk_blk,
    input logic              lk_hit,
    input logic [LINE_W-1:0] lk_line,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [TAG_W-1:0]  wb_blk,
    input logic [LINE_W-1:0] wb_line
);
    // R5
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_blk) && $stable(wb_line));

    // R2
    hit_frees_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_hit && !(ins_valid && ins_ready)
        |=> !(lk_valid && lk_blk == $past(lk_blk) && lk_hit));

    // R1
    insert_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid && ins_ready
        |=> !(lk_valid && lk_blk == $past(ins_blk)) || (lk_hit && lk_line == $past(ins_line)));

    // R4
    wb_from_insert_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_valid) |-> $past(ins_valid && ins_ready && !lk_hit));

    // R7
    swap_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid && ins_ready && lk_valid && lk_hit |=> !wb_valid);
endmodule

bind victim_buffer vc_checker #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_vc_checker (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ins_blk   (ins_blk),
    .ins_line  (ins_line),
    .lk_valid  (lk_valid),
    .lk_blk    (lk_blk),
    .lk_hit    (lk_hit),
    .lk_line   (lk_line),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_blk    (wb_blk),
    .wb_line   (wb_line)
);

// File: tb/test_victim_buffer.sv
module test_victim_buffer;
    localparam int N  = 8;
    localparam int TW = 22;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ins_valid = 1'b0;
    logic          ins_ready;
    logic [TW-1:0] ins_blk = '0;
    logic [LW-1:0] ins_line = '0;
    logic          ins_dirty = 1'b0;
    logic          lk_valid = 1'b0;
    logic [TW-1:0] lk_blk = '0;
    logic          lk_hit;
    logic [LW-1:0] lk_line;
    logic          lk_dirty;
    logic          wb_valid;
    logic          wb_ready = 1'b1;
    logic [TW-1:0] wb_blk;
    logic [LW-1:0] wb_line;

    always #5 clk = ~clk;

    victim_buffer #(.ENTRIES(N), .ADDR_W(24), .OFFSET_W(2)) i_victim_buffer (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_blk(ins_blk),
        .ins_line(ins_line), .ins_dirty(ins_dirty),
        .lk_valid(lk_valid), .lk_blk(lk_blk), .lk_hit(lk_hit),
        .lk_line(lk_line), .lk_dirty(lk_dirty),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_blk(wb_blk), .wb_line(wb_line)
    );

    int total = 0;
    int bad   = 0;

    // behavioural model: slots, arrival pointer, pending write-back
    bit            m_v [N];
    bit            m_d [N];
    logic [TW-1:0] m_t [N];
    logic [LW-1:0] m_x [N];
    int            m_ptr = 0;
    bit            m_wbv = 0;
    logic [TW-1:0] m_wbt = '0;
    logic [LW-1:0] m_wbx = '0;
    bit            last_fire = 0;

    task automatic check(string lbl, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", lbl, what, act, exp);
        end
    endtask

    task automatic step(string lbl);
        bit hit;
        int hi;
        int slot;
        #2;
        hit = 0;
        hi  = -1;
        if (lk_valid)
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_t[i] == lk_blk) begin
                    hit = 1;
                    hi  = i;
                end
        check(lbl, "lk_hit", 64'(lk_hit), 64'(hit));
        if (hit) begin
            check(lbl, "lk_line", 64'(lk_line), 64'(m_x[hi]));
            check(lbl, "lk_dirty", 64'(lk_dirty), 64'(m_d[hi]));
        end
        check(lbl, "ins_ready", 64'(ins_ready), 64'(!m_wbv));
        check(lbl, "wb_valid", 64'(wb_valid), 64'(m_wbv));
        if (m_wbv) begin
            check(lbl, "wb_blk", 64'(wb_blk), 64'(m_wbt));
            check(lbl, "wb_line", 64'(wb_line), 64'(m_wbx));
        end
        last_fire = ins_valid && !m_wbv;
        @(posedge clk);
        if (m_wbv && wb_ready) m_wbv = 0;
        if (hit) m_v[hi] = 0;
        if (last_fire) begin
            slot = -1;
            if (hit) slot = hi;
            else
                for (int i = N - 1; i >= 0; i--)
                    if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_ptr;
                if (m_d[slot]) begin
                    m_wbv = 1;
                    m_wbt = m_t[slot];
                    m_wbx = m_x[slot];
                end
                m_ptr = (m_ptr + 1) % N;
            end
            m_v[slot] = 1;
            m_d[slot] = ins_dirty;
            m_t[slot] = ins_blk;
            m_x[slot] = ins_line;
        end
        @(negedge clk);
    endtask

    task automatic drive(bit iv, int ib, bit id, bit lv, int lb, bit wr);
        ins_valid = iv;
        ins_blk   = TW'(ib);
        ins_line  = 32'hA500_0000 ^ LW'(ib * 32'h9E37);
        ins_dirty = id;
        lk_valid  = lv;
        lk_blk    = TW'(lb);
        wb_ready  = wr;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nt;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_t[i] = '0; m_x[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: empty after reset
        drive(0, 0, 0, 1, 'h100, 0);
        step("R8 reset state");

        // R3: fill free entries in order, odd blocks modified
        for (int i = 0; i < N; i++) begin
            drive(1, 'h100 + i, i[0], 0, 0, 1);
            step("R3 fill free entry");
        end
        // R1: hit returns the line
        drive(0, 0, 0, 1, 'h104, 1);
        step("R1 lookup hit");
        // R2: entry released
        drive(0, 0, 0, 1, 'h104, 1);
        step("R2 repeat lookup misses");
        // R3: freed entry refilled
        drive(1, 'h108, 0, 0, 0, 1);
        step("R3 refill freed entry");
        // R4: full, oldest slot 0 is clean
        drive(1, 'h109, 1, 0, 0, 1);
        step("R4 clean eviction");
        drive(0, 0, 0, 1, 'h100, 0);
        step("R4 evicted block gone");
        // R5: slot 1 modified -> write-back, held with wb_ready low
        drive(1, 'h10A, 0, 0, 0, 0);
        step("R5 modified eviction");
        // R6 and R9: refused inserts, lookups still served
        drive(1, 'h10B, 1, 1, 'h103, 0);
        step("R6 insert refused, R9 lookup served");
        drive(1, 'h10B, 1, 1, 'h101, 0);
        step("R6 insert refused, R9 pending block misses");
        drive(1, 'h10B, 1, 0, 0, 1);
        step("R5 write-back accepted");
        drive(1, 'h10B, 1, 0, 0, 1);
        step("R6 insert after release");
        // R7: swap
        drive(1, 'h10C, 1, 1, 'h105, 1);
        step("R7 swap insert with hit");
        drive(0, 0, 0, 1, 'h10C, 1);
        step("R7 swapped line present");
        drive(0, 0, 0, 1, 'h106, 1);
        step("R7 neighbour kept");
        // R4: keep inserting to wrap the pointer
        for (int i = 0; i < 2 * N; i++) begin
            drive(1, 'h200 + i, i[1], 0, 0, 1);
            step("R4 pointer wrap");
        end

        // random traffic with unique new blocks
        nt = 'h400;
        for (int k = 0; k < 600; k++) begin
            drive(($urandom % 3) != 0, nt, $urandom % 2,
                  ($urandom % 2) != 0, nt - 1 - int'($urandom % 14),
                  ($urandom % 3) != 0);
            step("R1 R4 R5 R6 R7 random traffic");
            if (last_fire) nt++;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule